// File: doc/BRIEF.md
# IPMI Request Dispatcher with Local Capability Answer

This block sits between a serial-bus receive buffer that holds one fully assembled IPMI request and a management controller. When the host hands over a request (length plus a one-cycle start strobe), the dispatcher reads the first three bytes of the buffer and classifies the request. A Get System Interface Capabilities request is answered on the spot: the dispatcher writes a fixed reply into the outgoing message buffer and never bothers the controller. Any other request goes to the controller as a single-cycle request pulse. That pulse carries the length and the tag the dispatcher is waiting on. The controller reads the request bytes from the shared buffer itself.

Controller replies come back as a byte stream with a tag on the first beat. Only a reply whose tag matches the outstanding one is written into the outgoing buffer. Accepting a reply advances the waiting tag. A reply longer than the outgoing buffer is cut to the buffer size, and its completion-code byte is overwritten to report the truncation. A rewind pulse tells the downstream chunking logic to restart its read position and block count, both when a request is accepted and when a reply is complete.

Top module: `ipmi_req_dispatch`

## Requirements
- R1: A request whose byte 0 is 0x18 and byte 1 is 0x57 is answered locally, and `ctl_req_valid` never pulses for it.
- R2: A local request with `req_len` below 3 gets a 3-byte reply 0x1C, 0x57, 0xC7 at addresses 0..2, and `out_len` is 3.
- R3: A local request of 3 or more bytes whose byte 2 has a nonzero low nibble gets the 3-byte reply 0x1C, 0x57, 0xCC. The high nibble of byte 2 is not examined.
- R4: Any other local request gets the 7-byte reply 0x1C, 0x57, 0x00, 0x00, 0x80, 0xFF, 0xFF, and `out_len` is 7.
- R5: Every other request produces exactly one single-cycle `ctl_req_valid` pulse, with `ctl_req_tag` equal to the waiting tag and `ctl_req_len` equal to `req_len`. The waiting tag is 0 after reset.
- R6: A reply stream is dropped if its first-beat tag differs from the waiting tag, or if it arrives while no forwarded request is outstanding. A dropped reply causes no buffer write and no change to `out_valid`.
- R7: A matching reply of N bytes (N ≤ 255) is written byte k at address k. `out_len` becomes N, and the next forwarded request carries the waiting tag plus one.
- R8: A matching reply of more than 255 bytes keeps only its first 255 bytes, has byte 2 replaced by 0xC6, and sets `out_len` to 255. A reply of exactly 255 bytes is kept unchanged.
- R9: `out_valid` is low from the cycle after an accepted `req_start` until the reply is complete. `out_rewind` pulses for one cycle on request acceptance and again on reply completion.
- R10: After reset, `out_valid`, `out_len`, `ctl_req_valid` and `out_rewind` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_start | input | 1 | One-cycle strobe: request buffer holds a complete request |
| req_len | input | 8 | Request length in bytes |
| req_raddr | output | 8 | Request buffer read address (one-cycle read latency) |
| req_rdata | input | 8 | Request buffer read data |
| ctl_req_valid | output | 1 | One-cycle pulse forwarding the request to the controller |
| ctl_req_tag | output | 8 | Tag of the forwarded request |
| ctl_req_len | output | 8 | Length of the forwarded request |
| ctl_rsp_valid | input | 1 | Controller reply byte valid |
| ctl_rsp_last | input | 1 | Last byte of the controller reply |
| ctl_rsp_tag | input | 8 | Reply tag, sampled on the first beat |
| ctl_rsp_data | input | 8 | Controller reply byte |
| rsp_wr_en | output | 1 | Outgoing buffer write enable |
| rsp_wr_addr | output | 8 | Outgoing buffer write address |
| rsp_wr_data | output | 8 | Outgoing buffer write data |
| out_valid | output | 1 | Outgoing buffer holds a complete reply |
| out_len | output | 8 | Length of the reply in the outgoing buffer |
| out_rewind | output | 1 | Pulse: reset downstream read position and block counter |

## Verification
The hardest situation to reach is an over-long controller reply. To get there, a request must first be forwarded and the waiting tag must already have advanced through earlier accepted replies. Only then can a 300-byte stream with the matching tag arrive and exercise both the address cut-off and the late overwrite of byte 2. The stimulus builds up to it in order: a wrong-tag reply while waiting, an accepted short reply, a second forward with the incremented tag, and then the long stream. An exact 255-byte reply follows to pin down the boundary, and a matching-tag stream sent while idle confirms that unsolicited replies are discarded.

// File: rtl/ipmi_disp_pkg.sv
// Shared constants and state type for the IPMI request dispatcher.
// Assumes byte-wide buffers; network function and completion codes are
// fixed by the message protocol.
package ipmi_disp_pkg;
    localparam logic [7:0] NETFN_APP      = 8'h06;
    localparam logic [7:0] REQ_NETFN_BYTE = 8'(NETFN_APP << 2);
    localparam logic [7:0] RSP_NETFN_BYTE = 8'((NETFN_APP + 8'd1) << 2);
    localparam logic [7:0] CMD_GET_CAPS   = 8'h57;
    localparam logic [7:0] CC_TRUNCATED   = 8'hC6;
    localparam logic [7:0] CC_BAD_LENGTH  = 8'hC7;
    localparam logic [7:0] CC_BAD_FIELD   = 8'hCC;
    localparam logic [7:0] CAP_MULTIPART  = 8'h80;
    localparam logic [7:0] CC_POS         = 8'd2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HDR,
        ST_DECIDE,
        ST_LOCAL,
        ST_WAIT,
        ST_FIX
    } disp_state_t;
endpackage

// File: rtl/ipmi_local_caps.sv
// Local capability reply generator.
// Given request byte 2 and the request length, returns the length of the
// locally generated reply (3 on error, 7 otherwise) and the byte at index
// idx. Purely combinational; assumes the caller has already matched the
// network function and command bytes.
module ipmi_local_caps
    import ipmi_disp_pkg::*;
#(
    parameter int MAX_MSG = 255,
    parameter int LEN_W   = 8
) (
    input  logic [7:0]       hdr2,
    input  logic [LEN_W-1:0] req_len,
    input  logic [2:0]       idx,
    output logic [2:0]       rep_len,
    output logic [7:0]       rep_byte
);
    logic too_short;
    logic bad_field;

    // Classify the request and pick the reply length.
    always_comb begin
        too_short = req_len < LEN_W'(3);
        bad_field = !too_short && (hdr2[3:0] != 4'h0);
        rep_len   = (too_short || bad_field) ? 3'd3 : 3'd7;
    end

    // Select the reply byte at position idx.
    always_comb begin
        unique case (idx)
            3'd0:    rep_byte = RSP_NETFN_BYTE;
            3'd1:    rep_byte = CMD_GET_CAPS;
            3'd2:    rep_byte = too_short ? CC_BAD_LENGTH :
                                bad_field ? CC_BAD_FIELD  : 8'h00;
            3'd3:    rep_byte = 8'h00;
            3'd4:    rep_byte = CAP_MULTIPART;
            3'd5:    rep_byte = 8'(MAX_MSG);
            3'd6:    rep_byte = 8'(MAX_MSG);
            default: rep_byte = 8'h00;
        endcase
    end
endmodule

// File: rtl/ipmi_rsp_capture.sv
// Controller reply capture.
// Tracks reply frames on a byte stream, accepts a frame only when its
// first-beat tag equals the waiting tag and the dispatcher is waiting,
// and writes accepted bytes to consecutive buffer addresses until the
// buffer is full. Signals completion on the last beat with the full count.
// Assumes every frame ends with a beat carrying rsp_last.
module ipmi_rsp_capture #(
    parameter int MAX_MSG = 255,
    parameter int TAG_W   = 8,
    parameter int LEN_W   = 8,
    parameter int CNT_W   = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wait_en,
    input  logic [TAG_W-1:0] wait_tag,
    input  logic             rsp_valid,
    input  logic             rsp_last,
    input  logic [TAG_W-1:0] rsp_tag,
    input  logic [7:0]       rsp_data,
    output logic             wr_en,
    output logic [LEN_W-1:0] wr_addr,
    output logic [7:0]       wr_data,
    output logic             done,
    output logic [CNT_W-1:0] total
);
    logic             in_frame;
    logic             acc_q;
    logic [CNT_W-1:0] cnt;
    logic             acc_cur;

    // Decide whether the current beat belongs to an accepted frame.
    always_comb begin
        acc_cur = (in_frame ? acc_q : (rsp_tag == wait_tag)) && wait_en;
        wr_en   = rsp_valid && acc_cur && (cnt < CNT_W'(MAX_MSG));
        wr_addr = cnt[LEN_W-1:0];
        wr_data = rsp_data;
        done    = rsp_valid && rsp_last && acc_cur;
        total   = cnt + CNT_W'(1);
    end

    // Frame tracker and saturating byte counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_frame <= 1'b0;
            acc_q    <= 1'b0;
            cnt      <= '0;
        end else if (rsp_valid) begin
            if (rsp_last) begin
                in_frame <= 1'b0;
                acc_q    <= 1'b0;
                cnt      <= '0;
            end else begin
                in_frame <= 1'b1;
                acc_q    <= acc_cur;
                if (cnt <= CNT_W'(MAX_MSG)) cnt <= cnt + CNT_W'(1);
            end
        end
    end

    // Writes only happen while the dispatcher waits for a reply (R6).
    p_wr_needs_wait_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> wait_en);
    // Buffer addresses stay inside the outgoing buffer (R8).
    p_addr_in_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_addr < LEN_W'(MAX_MSG)));
endmodule

// File: rtl/ipmi_req_dispatch.sv
// IPMI request dispatcher, top level.
// Reads the first three bytes of an assembled request, answers the
// interface-capabilities query locally, forwards everything else to the
// management controller with a tag, and captures the tagged reply into the
// outgoing buffer (truncating over-long replies). Assumes the request
// buffer has one-cycle read latency and stays stable until the reply is in.
module ipmi_req_dispatch
    import ipmi_disp_pkg::*;
#(
    parameter int MAX_MSG = 255,
    parameter int TAG_W   = 8,
    parameter int LEN_W   = $clog2(MAX_MSG + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_start,
    input  logic [LEN_W-1:0] req_len,
    output logic [LEN_W-1:0] req_raddr,
    input  logic [7:0]       req_rdata,
    output logic             ctl_req_valid,
    output logic [TAG_W-1:0] ctl_req_tag,
    output logic [LEN_W-1:0] ctl_req_len,
    input  logic             ctl_rsp_valid,
    input  logic             ctl_rsp_last,
    input  logic [TAG_W-1:0] ctl_rsp_tag,
    input  logic [7:0]       ctl_rsp_data,
    output logic             rsp_wr_en,
    output logic [LEN_W-1:0] rsp_wr_addr,
    output logic [7:0]       rsp_wr_data,
    output logic             out_valid,
    output logic [LEN_W-1:0] out_len,
    output logic             out_rewind
);
    localparam int CNT_W = LEN_W + 1;

    disp_state_t      state;
    logic [1:0]       hdr_cnt;
    logic [7:0]       hdr0, hdr1, hdr2;
    logic [LEN_W-1:0] len_q;
    logic [2:0]       widx;
    logic [TAG_W-1:0] wait_tag;
    logic             start_ok;
    logic             is_local;
    logic             wait_en;

    logic [2:0]       loc_len;
    logic [7:0]       loc_byte;
    logic             cap_wr_en;
    logic [LEN_W-1:0] cap_addr;
    logic [7:0]       cap_data;
    logic             cap_done;
    logic [CNT_W-1:0] cap_total;

    // Request acceptance and classification.
    always_comb begin
        start_ok  = req_start && ((state == ST_IDLE) || (state == ST_WAIT));
        wait_en   = (state == ST_WAIT) && !req_start;
        is_local  = (hdr0 == REQ_NETFN_BYTE) && (hdr1 == CMD_GET_CAPS);
        req_raddr = LEN_W'(hdr_cnt);
    end

    ipmi_local_caps #(.MAX_MSG(MAX_MSG), .LEN_W(LEN_W)) u_caps (
        .hdr2     (hdr2),
        .req_len  (len_q),
        .idx      (widx),
        .rep_len  (loc_len),
        .rep_byte (loc_byte)
    );

    ipmi_rsp_capture #(.MAX_MSG(MAX_MSG), .TAG_W(TAG_W), .LEN_W(LEN_W),
                       .CNT_W(CNT_W)) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .wait_en   (wait_en),
        .wait_tag  (wait_tag),
        .rsp_valid (ctl_rsp_valid),
        .rsp_last  (ctl_rsp_last),
        .rsp_tag   (ctl_rsp_tag),
        .rsp_data  (ctl_rsp_data),
        .wr_en     (cap_wr_en),
        .wr_addr   (cap_addr),
        .wr_data   (cap_data),
        .done      (cap_done),
        .total     (cap_total)
    );

    // Outgoing buffer write mux: local reply, truncation fix-up, or capture.
    always_comb begin
        if (state == ST_LOCAL) begin
            rsp_wr_en   = 1'b1;
            rsp_wr_addr = LEN_W'(widx);
            rsp_wr_data = loc_byte;
        end else if (state == ST_FIX) begin
            rsp_wr_en   = 1'b1;
            rsp_wr_addr = LEN_W'(CC_POS);
            rsp_wr_data = CC_TRUNCATED;
        end else begin
            rsp_wr_en   = cap_wr_en;
            rsp_wr_addr = cap_addr;
            rsp_wr_data = cap_data;
        end
    end

    // Main sequencer: header read, dispatch, local reply, reply completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state         <= ST_IDLE;
            hdr_cnt       <= '0;
            hdr0          <= '0;
            hdr1          <= '0;
            hdr2          <= '0;
            len_q         <= '0;
            widx          <= '0;
            wait_tag      <= '0;
            ctl_req_valid <= 1'b0;
            ctl_req_tag   <= '0;
            ctl_req_len   <= '0;
            out_valid     <= 1'b0;
            out_len       <= '0;
            out_rewind    <= 1'b0;
        end else begin
            out_rewind    <= 1'b0;
            ctl_req_valid <= 1'b0;
            if (start_ok) begin
                state      <= ST_HDR;
                hdr_cnt    <= '0;
                len_q      <= req_len;
                out_valid  <= 1'b0;
                out_rewind <= 1'b1;
            end else begin
                unique case (state)
                    ST_HDR: begin
                        hdr_cnt <= hdr_cnt + 2'd1;
                        if (hdr_cnt == 2'd1) hdr0 <= req_rdata;
                        if (hdr_cnt == 2'd2) hdr1 <= req_rdata;
                        if (hdr_cnt == 2'd3) begin
                            hdr2  <= req_rdata;
                            state <= ST_DECIDE;
                        end
                    end
                    ST_DECIDE: begin
                        if (is_local) begin
                            widx  <= '0;
                            state <= ST_LOCAL;
                        end else begin
                            ctl_req_valid <= 1'b1;
                            ctl_req_tag   <= wait_tag;
                            ctl_req_len   <= len_q;
                            state         <= ST_WAIT;
                        end
                    end
                    ST_LOCAL: begin
                        widx <= widx + 3'd1;
                        if (widx == loc_len - 3'd1) begin
                            out_valid  <= 1'b1;
                            out_len    <= LEN_W'(loc_len);
                            out_rewind <= 1'b1;
                            state      <= ST_IDLE;
                        end
                    end
                    ST_WAIT: begin
                        if (cap_done) begin
                            wait_tag <= wait_tag + TAG_W'(1);
                            if (cap_total > CNT_W'(MAX_MSG)) begin
                                state <= ST_FIX;
                            end else begin
                                out_valid  <= 1'b1;
                                out_len    <= cap_total[LEN_W-1:0];
                                out_rewind <= 1'b1;
                                state      <= ST_IDLE;
                            end
                        end
                    end
                    ST_FIX: begin
                        out_valid  <= 1'b1;
                        out_len    <= LEN_W'(MAX_MSG);
                        out_rewind <= 1'b1;
                        state      <= ST_IDLE;
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    // A local answer never raises a controller request (R1).
    p_local_no_fwd_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOCAL) |-> !ctl_req_valid);
    // A forwarded request is a single-cycle pulse (R5).
    p_fwd_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_req_valid |=> !ctl_req_valid);
    // Unsolicited replies while idle write nothing (R6).
    p_idle_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_IDLE) && ctl_rsp_valid) |-> !rsp_wr_en);
    // Accepting a reply advances the waiting tag by one (R7).
    p_tag_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wait_en && cap_done) |=> (wait_tag == $past(wait_tag) + TAG_W'(1)));
    // Accepted request drops the valid flag and rewinds the reader (R9).
    p_start_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        start_ok |=> (!out_valid && out_rewind));
endmodule

// File: tb/ipmi_req_dispatch_test.sv
module ipmi_req_dispatch_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_start = 1'b0;
    logic [7:0] req_len = '0;
    logic [7:0] req_raddr;
    logic [7:0] req_rdata = '0;
    logic       ctl_req_valid;
    logic [7:0] ctl_req_tag;
    logic [7:0] ctl_req_len;
    logic       ctl_rsp_valid = 1'b0;
    logic       ctl_rsp_last = 1'b0;
    logic [7:0] ctl_rsp_tag = '0;
    logic [7:0] ctl_rsp_data = '0;
    logic       rsp_wr_en;
    logic [7:0] rsp_wr_addr;
    logic [7:0] rsp_wr_data;
    logic       out_valid;
    logic [7:0] out_len;
    logic       out_rewind;

    always #5 clk = ~clk;

    ipmi_req_dispatch uut (
        .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_len(req_len),
        .req_raddr(req_raddr), .req_rdata(req_rdata),
        .ctl_req_valid(ctl_req_valid), .ctl_req_tag(ctl_req_tag),
        .ctl_req_len(ctl_req_len), .ctl_rsp_valid(ctl_rsp_valid),
        .ctl_rsp_last(ctl_rsp_last), .ctl_rsp_tag(ctl_rsp_tag),
        .ctl_rsp_data(ctl_rsp_data), .rsp_wr_en(rsp_wr_en),
        .rsp_wr_addr(rsp_wr_addr), .rsp_wr_data(rsp_wr_data),
        .out_valid(out_valid), .out_len(out_len), .out_rewind(out_rewind)
    );

    int   checks = 0;
    int   errors = 0;
    logic [7:0] reqmem [256];
    logic [7:0] smem [256];
    int   wr_cnt = 0;
    int   fwd_cnt = 0;
    int   rew_cnt = 0;
    logic [7:0] fwd_tag = '0;
    logic [7:0] fwd_len = '0;
    bit   hold_low = 1'b0;
    int   model_tag = 0;

    // Request buffer with one-cycle read latency.
    always @(posedge clk) req_rdata <= reqmem[req_raddr];

    // Shadow of the outgoing buffer and event counters.
    always @(posedge clk) begin
        if (rst_n) begin
            if (rsp_wr_en) begin
                smem[rsp_wr_addr] <= rsp_wr_data;
                wr_cnt <= wr_cnt + 1;
            end
            if (ctl_req_valid) begin
                fwd_cnt <= fwd_cnt + 1;
                fwd_tag <= ctl_req_tag;
                fwd_len <= ctl_req_len;
            end
            if (out_rewind) rew_cnt <= rew_cnt + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
        end
    endtask

    // Per-clock model compare: while a forwarded request is unanswered, out_valid stays low (R9).
    always @(negedge clk) begin
        if (rst_n && hold_low) chk(out_valid == 1'b0, "R9 valid low while waiting", int'(out_valid), 0);
    end

    function automatic logic [7:0] rbyte(input int i, input int seed);
        return 8'((i * 7 + seed) & 8'hFF);
    endfunction

    task automatic do_req(input int len, input logic [7:0] b0, input logic [7:0] b1,
                          input logic [7:0] b2, input bit fwd);
        reqmem[0] = b0; reqmem[1] = b1; reqmem[2] = b2;
        for (int i = 3; i < 256; i++) reqmem[i] = 8'(i);
        @(negedge clk);
        req_len = 8'(len);
        req_start = 1'b1;
        @(negedge clk);
        req_start = 1'b0;
        if (fwd) hold_low = 1'b1;
        repeat (14) @(negedge clk);
    endtask

    task automatic send_rsp(input logic [7:0] tag, input int n, input int seed, input bit match);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            ctl_rsp_valid = 1'b1;
            ctl_rsp_last = (i == n - 1);
            ctl_rsp_tag = tag;
            ctl_rsp_data = rbyte(i, seed);
            if (match && i == n - 1) hold_low = 1'b0;
        end
        @(negedge clk);
        ctl_rsp_valid = 1'b0;
        ctl_rsp_last = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (2000000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int w0, f0, r0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state.
        chk(out_valid == 0, "R10 out_valid", int'(out_valid), 0);
        chk(out_len == 0, "R10 out_len", int'(out_len), 0);
        chk(ctl_req_valid == 0, "R10 ctl_req_valid", int'(ctl_req_valid), 0);
        chk(out_rewind == 0, "R10 out_rewind", int'(out_rewind), 0);

        // R4 / R1: valid local query.
        f0 = fwd_cnt; r0 = rew_cnt;
        do_req(3, 8'h18, 8'h57, 8'h00, 1'b0);
        chk(fwd_cnt == f0, "R1 not forwarded", fwd_cnt, f0);
        chk(out_valid == 1, "R4 out_valid", int'(out_valid), 1);
        chk(out_len == 7, "R4 out_len", int'(out_len), 7);
        chk(smem[0] == 8'h1C, "R4 byte0", int'(smem[0]), 8'h1C);
        chk(smem[1] == 8'h57, "R4 byte1", int'(smem[1]), 8'h57);
        chk(smem[2] == 8'h00, "R4 byte2", int'(smem[2]), 0);
        chk(smem[3] == 8'h00, "R4 byte3", int'(smem[3]), 0);
        chk(smem[4] == 8'h80, "R4 byte4", int'(smem[4]), 8'h80);
        chk(smem[5] == 8'hFF, "R4 byte5", int'(smem[5]), 8'hFF);
        chk(smem[6] == 8'hFF, "R4 byte6", int'(smem[6]), 8'hFF);
        chk(rew_cnt == r0 + 2, "R9 rewind pulses", rew_cnt, r0 + 2);

        // R2: too short.
        do_req(2, 8'h18, 8'h57, 8'h00, 1'b0);
        chk(out_len == 3, "R2 out_len", int'(out_len), 3);
        chk(smem[0] == 8'h1C && smem[1] == 8'h57, "R2 header", int'(smem[1]), 8'h57);
        chk(smem[2] == 8'hC7, "R2 cc", int'(smem[2]), 8'hC7);

        // R3: nonzero low nibble.
        do_req(3, 8'h18, 8'h57, 8'h05, 1'b0);
        chk(out_len == 3, "R3 out_len", int'(out_len), 3);
        chk(smem[2] == 8'hCC, "R3 cc", int'(smem[2]), 8'hCC);
        // R3: high nibble ignored.
        do_req(4, 8'h18, 8'h57, 8'h50, 1'b0);
        chk(out_len == 7, "R3 high nibble ignored", int'(out_len), 7);
        chk(smem[2] == 8'h00, "R3 high nibble cc", int'(smem[2]), 0);
        chk(fwd_cnt == f0, "R1 still none forwarded", fwd_cnt, f0);

        // R5: forwarded request.
        do_req(5, 8'h18, 8'h01, 8'h00, 1'b1);
        chk(fwd_cnt == f0 + 1, "R5 one pulse", fwd_cnt, f0 + 1);
        chk(fwd_tag == 8'(model_tag), "R5 tag", int'(fwd_tag), model_tag);
        chk(fwd_len == 8'd5, "R5 len", int'(fwd_len), 5);
        chk(out_valid == 0, "R9 valid low after start", int'(out_valid), 0);

        // R6: wrong tag dropped.
        w0 = wr_cnt;
        send_rsp(8'(model_tag + 3), 6, 11, 1'b0);
        chk(wr_cnt == w0, "R6 wrong tag no writes", wr_cnt, w0);
        chk(out_valid == 0, "R6 wrong tag no valid", int'(out_valid), 0);

        // R7: matching reply.
        r0 = rew_cnt;
        send_rsp(8'(model_tag), 10, 3, 1'b1);
        model_tag++;
        chk(out_valid == 1, "R7 out_valid", int'(out_valid), 1);
        chk(out_len == 10, "R7 out_len", int'(out_len), 10);
        chk(smem[0] == rbyte(0, 3), "R7 byte0", int'(smem[0]), int'(rbyte(0, 3)));
        chk(smem[9] == rbyte(9, 3), "R7 byte9", int'(smem[9]), int'(rbyte(9, 3)));
        chk(rew_cnt == r0 + 1, "R9 rewind on reply", rew_cnt, r0 + 1);

        // R8: over-long reply, tag advanced (R7).
        do_req(9, 8'h2C, 8'h22, 8'h00, 1'b1);
        chk(fwd_tag == 8'(model_tag), "R7 next tag", int'(fwd_tag), model_tag);
        send_rsp(8'(model_tag), 300, 5, 1'b1);
        model_tag++;
        chk(out_len == 255, "R8 truncated len", int'(out_len), 255);
        chk(smem[2] == 8'hC6, "R8 cc overwritten", int'(smem[2]), 8'hC6);
        chk(smem[3] == rbyte(3, 5), "R8 byte3", int'(smem[3]), int'(rbyte(3, 5)));
        chk(smem[254] == rbyte(254, 5), "R8 byte254", int'(smem[254]), int'(rbyte(254, 5)));

        // R8: exactly 255 bytes kept.
        do_req(7, 8'h2C, 8'h23, 8'h00, 1'b1);
        chk(fwd_tag == 8'(model_tag), "R7 tag again", int'(fwd_tag), model_tag);
        send_rsp(8'(model_tag), 255, 9, 1'b1);
        model_tag++;
        chk(out_len == 255, "R8 exact len", int'(out_len), 255);
        chk(smem[2] == rbyte(2, 9), "R8 exact byte2", int'(smem[2]), int'(rbyte(2, 9)));

        // R6: matching tag while idle is dropped.
        w0 = wr_cnt;
        send_rsp(8'(model_tag), 4, 1, 1'b0);
        chk(wr_cnt == w0, "R6 idle no writes", wr_cnt, w0);
        chk(out_len == 255, "R6 idle len unchanged", int'(out_len), 255);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule